// File: doc/BRIEF.md
# Instruction Address Match Interrupt Unit

This unit sits beside a CPU core's decode stage and watches the start address of each instruction the core is about to execute. Software loads up to four watch addresses and their enable bits through a small write port. When a newly presented instruction start address equals an enabled watch address, the unit raises a one-cycle interrupt request before that instruction runs. The request has no mask input, so it cannot be held off by the core's global interrupt flag or its priority level.

With each request the unit reports which watch slot fired and a program counter value for the core to push on the stack. This value is deliberately not a return address. It is the watch address plus 2 when the decoder flags the instruction as a long-opcode or short-immediate form, and plus 1 otherwise. Matching is suppressed for instructions fetched from an external area while the external bus is configured 8 bits wide.

Writes to the watch registers apply to instruction starts presented after the write's clock edge. A stalled decoder that holds the same fetch for several cycles produces only one request.

Top module: `addr_match_irq`

## Requirements
- R1: After reset every watch address is 0 and every enable is clear. No request is raised, including for a fetch of address 0.
- R2: An instruction start whose address equals an enabled watch address raises `brk_req` for exactly one cycle, visible after the clock edge on which the fetch was presented.
- R3: Write code N_SRC (4) sets the enables of slots 0 and 1 from data bits 0 and 1. Write code N_SRC+1 (5) sets the enables of slots 2 and 3 from data bits 0 and 1. All other data bits in these writes are ignored. Write codes 0 to 3 load the watch address of the slot with the same number.
- R4: A slot whose enable is clear never causes a request, even when its address matches.
- R5: When several enabled slots match, one request is raised and `brk_src` gives the lowest-numbered matching slot.
- R6: With a request, `brk_stack_pc` equals the fetch address plus 2 when `fetch_long` is 1, and plus 1 when it is 0. The sum wraps modulo 2^ADDR_W.
- R7: No request is raised when `ext_area` and `bus_narrow` are both 1. Either one alone does not block a match.
- R8: An instruction start is a cycle with `fetch_vld` high where the previous cycle did not present the same address with `fetch_vld` high. A repeated or stalled presentation raises no further request.
- R9: A register write takes effect for instruction starts presented on later edges. A fetch presented on the same edge as the write is compared against the old contents.
- R10: Writes with codes 6 and 7 change no watch address and no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | SEL_W (3) | Register code: 0..3 watch address, 4..5 enable groups |
| cfg_data | input | ADDR_W (20) | Write data |
| fetch_vld | input | 1 | Decoder presents an instruction start address |
| fetch_addr | input | ADDR_W (20) | Instruction start address |
| fetch_long | input | 1 | Instruction belongs to the plus-two class |
| ext_area | input | 1 | Address lies in an external area |
| bus_narrow | input | 1 | External bus configured 8 bits wide |
| brk_req | output | 1 | One-cycle match interrupt request |
| brk_src | output | IDX_W (2) | Lowest matching slot number |
| brk_stack_pc | output | ADDR_W (20) | Program counter value to stack |

## Verification
Every result appears one clock edge after the fetch that causes it. `brk_req`, `brk_src` and `brk_stack_pc` all come from a single output register, and a write presented on the same edge is compared against the old contents. The bench drives each fetch and write on a falling edge. It then compares the outputs on the next falling edge against a model evaluated before that write is applied, so each sample lands after exactly one register stage. `brk_src` and `brk_stack_pc` are checked only in cycles where a request is expected.

// File: rtl/ami_pkg.sv
package ami_pkg;
  // enable bits held per enable register
  localparam int ENA_PER_REG = 2;

  function automatic int sel_width(input int n_src);
    return $clog2(n_src + (n_src + ENA_PER_REG - 1) / ENA_PER_REG + 1);
  endfunction
endpackage

// File: rtl/ami_regs.sv
module ami_regs
  import ami_pkg::*;
#(
  parameter int AW = 20,
  parameter int NS = 4,
  parameter int SW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [SW-1:0]        sel,
  input  logic [AW-1:0]        data,
  output logic [NS-1:0][AW-1:0] watch_addr,
  output logic [NS-1:0]        watch_en
);
  localparam int N_EN_REG = (NS + ENA_PER_REG - 1) / ENA_PER_REG;
  localparam int LAST_CODE = NS + N_EN_REG - 1;

  for (genvar i = 0; i < NS; i++) begin : g_slot
    localparam logic [SW-1:0] ADDR_CODE = SW'(i);
    localparam logic [SW-1:0] EN_CODE   = SW'(NS + i / ENA_PER_REG);
    localparam int            EN_BIT    = i % ENA_PER_REG;

    logic addr_we, en_we;
    logic [AW-1:0] addr_d;
    logic en_d;

    always_comb begin
      addr_we = wr && (sel == ADDR_CODE);
      en_we   = wr && (sel == EN_CODE);
      addr_d  = data;
      en_d    = data[EN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        watch_addr[i] <= '0;
      end else if (addr_we) begin
        watch_addr[i] <= addr_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        watch_en[i] <= 1'b0;
      end else if (en_we) begin
        watch_en[i] <= en_d;
      end
    end
  end

  // R10: unused codes leave every register untouched
  a_r10_unused_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (int'(sel) > LAST_CODE)) |=> ($stable(watch_addr) && $stable(watch_en)));

  // R3: enable-group write loads the addressed enables from data bits 0 and 1
  a_r3_group0_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (sel == SW'(NS))) |=> (watch_en[1:0] == $past(data[1:0])));
endmodule

// File: rtl/ami_start.sv
module ami_start #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fv,
  input  logic [AW-1:0] addr,
  output logic          start
);
  logic          prev_fv_q, prev_fv_d;
  logic [AW-1:0] prev_addr_q, prev_addr_d;
  logic          addr_ce;

  always_comb begin
    prev_fv_d   = fv;
    addr_ce     = fv;
    prev_addr_d = addr;
    start       = fv && !(prev_fv_q && (addr == prev_addr_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_fv_q <= 1'b0;
    end else begin
      prev_fv_q <= prev_fv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr_q <= '0;
    end else if (addr_ce) begin
      prev_addr_q <= prev_addr_d;
    end
  end

  // R8: a held fetch of the same address is not a new start
  a_r8_no_restart_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fv && $past(fv) && (addr == $past(addr))) |-> !start);
endmodule

// File: rtl/ami_cmp.sv
module ami_cmp #(
  parameter int AW = 20,
  parameter int NS = 4,
  parameter int IW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr,
  input  logic                  blocked,
  input  logic [NS-1:0][AW-1:0] watch_addr,
  input  logic [NS-1:0]         watch_en,
  output logic                  any_hit,
  output logic [IW-1:0]         hit_idx
);
  logic [NS-1:0] hits;
  logic [NS-1:0] grant;

  for (genvar i = 0; i < NS; i++) begin : g_cmp
    assign hits[i] = watch_en[i] && (watch_addr[i] == addr) && !blocked;
  end

  always_comb begin
    any_hit = 1'b0;
    grant   = '0;
    hit_idx = '0;
    for (int i = 0; i < NS; i++) begin
      if (hits[i] && !any_hit) begin
        any_hit  = 1'b1;
        grant[i] = 1'b1;
        hit_idx  = IW'(i);
      end
    end
  end

  // R5: a single grant, and none below it also matching
  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (hits[hit_idx] && ((hits & ~({NS{1'b1}} << hit_idx)) == '0)));
  // R4: a granted slot is enabled
  a_r4_grant_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~watch_en) == '0));
endmodule

// File: rtl/addr_match_irq.sv
module addr_match_irq
  import ami_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int N_SRC  = 4,
  localparam int SEL_W = sel_width(N_SRC),
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              fetch_vld,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_long,
  input  logic              ext_area,
  input  logic              bus_narrow,
  output logic              brk_req,
  output logic [IDX_W-1:0]  brk_src,
  output logic [ADDR_W-1:0] brk_stack_pc
);
  logic [N_SRC-1:0][ADDR_W-1:0] watch_addr;
  logic [N_SRC-1:0]             watch_en;
  logic                         start;
  logic                         any_hit;
  logic [IDX_W-1:0]             hit_idx;
  logic                         blocked;

  logic                         req_d, req_q;
  logic                         out_ce;
  logic [IDX_W-1:0]             src_d, src_q;
  logic [ADDR_W-1:0]            pc_d, pc_q;

  ami_regs #(.AW(ADDR_W), .NS(N_SRC), .SW(SEL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (cfg_wr),
    .sel        (cfg_sel),
    .data       (cfg_data),
    .watch_addr (watch_addr),
    .watch_en   (watch_en)
  );

  ami_start #(.AW(ADDR_W)) u_start (
    .clk   (clk),
    .rst_n (rst_n),
    .fv    (fetch_vld),
    .addr  (fetch_addr),
    .start (start)
  );

  assign blocked = ext_area && bus_narrow;

  ami_cmp #(.AW(ADDR_W), .NS(N_SRC), .IW(IDX_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (fetch_addr),
    .blocked    (blocked),
    .watch_addr (watch_addr),
    .watch_en   (watch_en),
    .any_hit    (any_hit),
    .hit_idx    (hit_idx)
  );

  always_comb begin
    req_d  = start && any_hit;
    out_ce = req_d;
    src_d  = hit_idx;
    pc_d   = fetch_addr + (fetch_long ? ADDR_W'(2) : ADDR_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      pc_q  <= '0;
    end else if (out_ce) begin
      src_q <= src_d;
      pc_q  <= pc_d;
    end
  end

  assign brk_req      = req_q;
  assign brk_src      = src_q;
  assign brk_stack_pc = pc_q;

  // R2: a request always follows a valid fetch
  a_r2_req_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(fetch_vld));
  // R7: narrow external fetches never request
  a_r7_narrow_ext_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> !$past(ext_area && bus_narrow));
  // R6: stacked PC offset chosen by the opcode class
  a_r6_stack_pc: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (brk_stack_pc == $past(fetch_addr) + ($past(fetch_long) ? ADDR_W'(2) : ADDR_W'(1))));
  // R8: a stalled fetch gives no second request
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && $past(fetch_vld) && (fetch_addr == $past(fetch_addr))) |=> !brk_req);
endmodule

// File: tb/addr_match_irq_tb.sv
module addr_match_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk;
  logic          rst_n;
  logic          cfg_wr;
  logic [2:0]    cfg_sel;
  logic [AW-1:0] cfg_data;
  logic          fetch_vld;
  logic [AW-1:0] fetch_addr;
  logic          fetch_long;
  logic          ext_area;
  logic          bus_narrow;
  logic          brk_req;
  logic [1:0]    brk_src;
  logic [AW-1:0] brk_stack_pc;

  int checks;
  int fails;

  // bench model
  logic [AW-1:0] m_addr [4];
  bit            m_en   [4];
  bit            p_fv;
  logic [AW-1:0] p_addr;

  addr_match_irq u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_sel      (cfg_sel),
    .cfg_data     (cfg_data),
    .fetch_vld    (fetch_vld),
    .fetch_addr   (fetch_addr),
    .fetch_long   (fetch_long),
    .ext_area     (ext_area),
    .bus_narrow   (bus_narrow),
    .brk_req      (brk_req),
    .brk_src      (brk_src),
    .brk_stack_pc (brk_stack_pc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at the falling edge, check at the next falling edge
  task automatic step(input string tag, input bit wv, input logic [2:0] ws, input logic [AW-1:0] wd,
                      input bit fv, input logic [AW-1:0] fa, input bit lng, input bit ext, input bit nar);
    bit            st;
    bit            found;
    int            idx;
    logic [AW-1:0] epc;
    cfg_wr = wv; cfg_sel = ws; cfg_data = wd;
    fetch_vld = fv; fetch_addr = fa; fetch_long = lng; ext_area = ext; bus_narrow = nar;
    st = fv && !(p_fv && fa == p_addr);
    found = 1'b0;
    idx = 0;
    for (int i = 0; i < 4; i++) begin
      if (!found && m_en[i] && m_addr[i] == fa && !(ext && nar)) begin
        found = 1'b1;
        idx = i;
      end
    end
    epc = fa + (lng ? 20'd2 : 20'd1);
    p_fv = fv;
    if (fv) p_addr = fa;
    if (wv) begin
      if (ws < 3'd4) m_addr[ws] = wd;
      else if (ws == 3'd4) begin m_en[0] = wd[0]; m_en[1] = wd[1]; end
      else if (ws == 3'd5) begin m_en[2] = wd[0]; m_en[3] = wd[1]; end
    end
    @(negedge clk);
    check(tag, "brk_req", 32'(brk_req), 32'(st && found));
    if (st && found) begin
      check(tag, "brk_src", 32'(brk_src), 32'(idx));
      check(tag, "brk_stack_pc", 32'(brk_stack_pc), 32'(epc));
    end
  endtask

  task automatic wr(input string tag, input logic [2:0] ws, input logic [AW-1:0] wd);
    step(tag, 1'b1, ws, wd, 1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic fetch(input string tag, input logic [AW-1:0] fa, input bit lng, input bit ext, input bit nar);
    step(tag, 1'b0, 3'd0, '0, 1'b1, fa, lng, ext, nar);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 3'd0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not end actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0;
    fails = 0;
    for (int i = 0; i < 4; i++) begin m_addr[i] = '0; m_en[i] = 1'b0; end
    p_fv = 1'b0;
    p_addr = '0;
    void'($urandom(32'd24681));
    rst_n = 1'b0;
    cfg_wr = 1'b0; cfg_sel = '0; cfg_data = '0;
    fetch_vld = 1'b0; fetch_addr = '0; fetch_long = 1'b0; ext_area = 1'b0; bus_narrow = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "brk_req after reset", 32'(brk_req), 32'd0);

    // R1: address 0 equals the reset watch value but slots are disabled
    fetch("R1", 20'h00000, 1'b0, 1'b0, 1'b0);
    idle("R1");

    // R3: enable slots 0 and 1; R9: write slot 0 on the same edge as its fetch
    wr("R3", 3'd4, 20'h00003);
    step("R9", 1'b1, 3'd0, 20'h00100, 1'b1, 20'h00100, 1'b0, 1'b0, 1'b0);
    idle("R9");
    fetch("R2", 20'h00100, 1'b0, 1'b0, 1'b0);
    // R8: stalled presentation, then a new address, then back
    fetch("R8", 20'h00100, 1'b0, 1'b0, 1'b0);
    fetch("R8", 20'h00100, 1'b0, 1'b0, 1'b0);
    fetch("R8", 20'h00200, 1'b0, 1'b0, 1'b0);
    fetch("R8", 20'h00100, 1'b1, 1'b0, 1'b0);
    idle("R6");
    // R6: plus-two wraps at the top of the address space
    wr("R6", 3'd1, 20'hFFFFF);
    fetch("R6", 20'hFFFFF, 1'b1, 1'b0, 1'b0);
    fetch("R6", 20'h00100, 1'b0, 1'b0, 1'b0);
    // R5: slots 2 and 3 share an address, then slot 1 joins them
    wr("R5", 3'd2, 20'h00300);
    wr("R5", 3'd3, 20'h00300);
    wr("R3", 3'd5, 20'h00003);
    fetch("R5", 20'h00300, 1'b0, 1'b0, 1'b0);
    wr("R5", 3'd1, 20'h00300);
    fetch("R5", 20'h00300, 1'b1, 1'b0, 1'b0);
    // R4 / R3: clear slot 1 only; upper data bits ignored
    wr("R4", 3'd4, 20'hFFFFD);
    fetch("R4", 20'h00300, 1'b0, 1'b0, 1'b0);
    fetch("R4", 20'h00100, 1'b0, 1'b0, 1'b0);
    wr("R3", 3'd5, 20'hFFFFE);
    fetch("R3", 20'h00300, 1'b0, 1'b0, 1'b0);
    idle("R3");
    // R7: external area on a narrow bus
    fetch("R7", 20'h00300, 1'b0, 1'b1, 1'b1);
    fetch("R7", 20'h00100, 1'b0, 1'b1, 1'b1);
    fetch("R7", 20'h00300, 1'b0, 1'b1, 1'b0);
    fetch("R7", 20'h00100, 1'b0, 1'b0, 1'b1);
    // R10: unused codes change nothing
    wr("R10", 3'd6, 20'h00000);
    wr("R10", 3'd7, 20'h00001);
    fetch("R10", 20'h00300, 1'b0, 1'b0, 1'b0);
    fetch("R10", 20'h00100, 1'b1, 1'b0, 1'b0);
    fetch("R10", 20'h00000, 1'b0, 1'b0, 1'b0);

    // random phase over a small address pool
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] pool [4];
      bit            wv;
      logic [2:0]    ws;
      logic [AW-1:0] wd;
      bit            fv;
      logic [AW-1:0] fa;
      pool[0] = 20'h00100; pool[1] = 20'h00300; pool[2] = 20'hFFFFF; pool[3] = 20'h00040;
      wv = ($urandom % 8) == 0;
      ws = 3'($urandom % 8);
      wd = (ws >= 3'd4) ? 20'($urandom) : pool[$urandom % 4];
      fv = ($urandom % 5) != 0;
      if (($urandom % 3) == 0) fa = p_addr;
      else fa = pool[$urandom % 4];
      step("R2", wv, ws, wd, fv, fa, 1'($urandom), (($urandom % 4) == 0), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule